// File: doc/BRIEF.md
# Delayed Per-Tensor Scale Manager

This block keeps the scaling state for one tensor in a low-precision training pipeline. Each iteration the pipeline hands it the tensor's absolute maximum, as an unsigned fixed-point value, together with a flag that says whether the previous step overflowed. On a fixed cadence of iterations the block computes a fresh scale: the largest value of the target format divided by the absolute maximum plus one least significant bit. It computes this with a bit-serial divider and writes the result into a window of the 32 most recent scales. The scale the pipeline should apply is the arithmetic mean of that window. The mean is kept as a running sum, so it never needs an adder tree.

When an overflow is reported, the block does not compute a new scale. It shrinks its current scale by roughly one percent and counts the event. While the divider is working, the block refuses new iterations and marks its output as not yet updated. A synchronous clear brings every register back to its starting state.

Scales are unsigned fixed-point numbers with SCALE_FRAC fractional bits (8 by default). The absolute maximum carries AMAX_FRAC fractional bits (8 by default). The format maximum defaults to 240.

Top module: `scale_tracker`

## Requirements
- R1: After reset, scale_out and cur_scale both equal 2^16 (code 0x0100_0000 with 8 fraction bits). iter_cnt and ovf_cnt are 0, and iter_ready and scale_valid are 1.
- R2: The window holds 32 scales, the newest first. Each push drops the oldest entry, and all 32 entries start at 2^16.
- R3: An iteration accepted without overflow computes a new scale only when the number of iterations accepted before it, since reset or clear, is a multiple of PERIOD (default 4). The first such iteration computes one.
- R4: The computed scale is floor(FMAX·2^(AMAX_FRAC+SCALE_FRAC) / (amax + 1)), where amax is the raw input code. With the defaults this is floor(15728640 / (amax+1)). It becomes cur_scale and is pushed into the window.
- R5: scale_out equals floor(sum of the 32 window entries / 32).
- R6: An iteration accepted with ovf_in = 1 increments ovf_cnt. It starts no divide and pushes nothing, so scale_out does not change. It takes priority over a scheduled update, which is then skipped for that iteration, although the cadence still advances.
- R7: On an overflow iteration, cur_scale becomes s − (s>>7) − (s>>9).
- R8: After an update iteration is accepted, iter_ready and scale_valid stay low for SCALE_W+1 cycles (33 by default). An iter_valid presented in those cycles is not accepted and changes no counter or scale.
- R9: iter_cnt increments by one for each accepted iteration and wraps at 2^CNT_W.
- R10: clr = 1 restores the state of R1 at the next clock edge, including the window, and it aborts a divide in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear to the initial state |
| iter_valid | input | 1 | An iteration is presented |
| iter_ready | output | 1 | Block can accept an iteration |
| amax | input | AMAX_W (16) | Tensor absolute maximum, unsigned fixed point |
| ovf_in | input | 1 | Previous step overflowed |
| scale_out | output | SCALE_W (32) | Mean of the scale window, scale to apply |
| scale_valid | output | 1 | scale_out reflects all accepted iterations |
| cur_scale | output | SCALE_W (32) | Most recent scale (computed or backed off) |
| iter_cnt | output | CNT_W (16) | Accepted iteration count |
| ovf_cnt | output | CNT_W (16) | Overflow event count |

## Verification
The hardest case to reach is a full turnover of the 32-entry window with overflow iterations mixed in. In that case the running sum must subtract exactly the entry a push evicts, and a skipped update must leave the cadence intact. The stimulus runs well over 128 iterations, with amax values that include 0 and 0xFFFF and an overflow on every seventh iteration, so that updates are skipped at shifting positions. During each divide, the bench holds iter_valid high with junk inputs and then shows that the counters did not move. One clear is issued in the middle of a divide.

// File: rtl/scale_pkg.sv
package scale_pkg;
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_BACKOFF = 2'd1,
    ACT_UPDATE  = 2'd2
  } iter_act_e;
endpackage

// File: rtl/scale_divider.sv
module scale_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] num_q;
  logic [CW-1:0]    cnt_q;
  logic [DEN_W:0]   rem_sh;
  logic             take;

  assign rem_sh = {rem_q, quo[NUM_W-1]};
  assign take   = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; quo <= '0; rem_q <= '0;
      den_q <= '0; num_q <= '0; cnt_q <= '0;
    end else if (clr) begin
      busy <= 1'b0; done <= 1'b0; cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        cnt_q <= CW'(NUM_W);
        rem_q <= '0;
        quo   <= num;
        num_q <= num;
        den_q <= den;
      end else if (busy) begin
        quo   <= {quo[NUM_W-2:0], take};
        rem_q <= take ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R4: the result at completion is an exact floor division
  p_quotient_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((64'(quo) * 64'(den_q) + 64'(rem_q) == 64'(num_q)) && (rem_q < den_q)));

  // R8: completion is a single-cycle event
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/scale_history.sv
module scale_history #(
  parameter int W     = 32,
  parameter int LOG2  = 5,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] mean
);
  localparam int DEPTH = 1 << LOG2;
  localparam int SW    = W + LOG2;
  localparam logic [SW-1:0] SUM_INIT = SW'(INIT) << LOG2;

  logic [W-1:0]  hist [DEPTH];
  logic [SW-1:0] sum_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hist[k] <= INIT;
      else if (clr)  hist[k] <= INIT;
      else if (push) hist[k] <= (k == 0) ? din : hist[(k == 0) ? 0 : k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum_q <= SUM_INIT;
    else if (clr)  sum_q <= SUM_INIT;
    else if (push) sum_q <= sum_q + SW'(din) - SW'(hist[DEPTH-1]);
  end

  assign mean = W'(sum_q >> LOG2);

  // R5: the mean moves only on a push or a clear
  p_mean_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !clr) |=> $stable(mean));
endmodule

// File: rtl/scale_tracker.sv
module scale_tracker
  import scale_pkg::*;
#(
  parameter int SCALE_W    = 32,
  parameter int SCALE_FRAC = 8,
  parameter int AMAX_W     = 16,
  parameter int AMAX_FRAC  = 8,
  parameter int FMAX       = 240,
  parameter int HIST_LOG2  = 5,
  parameter int PERIOD     = 4,
  parameter int CNT_W      = 16,
  parameter int INIT_EXP   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               iter_valid,
  output logic               iter_ready,
  input  logic [AMAX_W-1:0]  amax,
  input  logic               ovf_in,
  output logic [SCALE_W-1:0] scale_out,
  output logic               scale_valid,
  output logic [SCALE_W-1:0] cur_scale,
  output logic [CNT_W-1:0]   iter_cnt,
  output logic [CNT_W-1:0]   ovf_cnt
);
  localparam int DEN_W = AMAX_W + 1;
  localparam int PH_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [SCALE_W-1:0] INIT_SCALE = SCALE_W'(1) << (INIT_EXP + SCALE_FRAC);
  localparam logic [SCALE_W-1:0] NUMERATOR  = SCALE_W'(FMAX) << (AMAX_FRAC + SCALE_FRAC);

  function automatic logic [SCALE_W-1:0] backoff(input logic [SCALE_W-1:0] s);
    return s - (s >> 7) - (s >> 9);
  endfunction

  logic [PH_W-1:0]    phase_q;
  logic               accept, div_start, div_busy, div_done, push, busy;
  logic [SCALE_W-1:0] div_quo;
  iter_act_e          act;

  assign busy        = div_busy | div_done;
  assign iter_ready  = !busy;
  assign scale_valid = !busy;
  assign accept      = iter_valid && iter_ready && !clr;

  always_comb begin
    if (ovf_in)                      act = ACT_BACKOFF;
    else if (phase_q == PH_W'(0))    act = ACT_UPDATE;
    else                             act = ACT_NONE;
  end

  assign div_start = accept && (act == ACT_UPDATE);
  assign push      = div_done && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_scale <= INIT_SCALE; phase_q <= '0; iter_cnt <= '0; ovf_cnt <= '0;
    end else if (clr) begin
      cur_scale <= INIT_SCALE; phase_q <= '0; iter_cnt <= '0; ovf_cnt <= '0;
    end else begin
      if (accept) begin
        iter_cnt <= iter_cnt + 1'b1;
        phase_q  <= (phase_q == PH_W'(PERIOD - 1)) ? '0 : phase_q + 1'b1;
        if (act == ACT_BACKOFF) begin
          ovf_cnt   <= ovf_cnt + 1'b1;
          cur_scale <= backoff(cur_scale);
        end
      end
      if (div_done) cur_scale <= div_quo;
    end
  end

  scale_divider #(.NUM_W(SCALE_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(div_start),
    .num(NUMERATOR), .den(DEN_W'(amax) + DEN_W'(1)),
    .busy(div_busy), .done(div_done), .quo(div_quo)
  );

  scale_history #(.W(SCALE_W), .LOG2(HIST_LOG2), .INIT(INIT_SCALE)) u_hist (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push),
    .din(div_quo), .mean(scale_out)
  );

  // R6: an overflow iteration advances the overflow counter by one
  p_ovf_count_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (accept && ovf_in) |=> (ovf_cnt == $past(ovf_cnt) + 1'b1));

  // R7: backoff strictly lowers any scale large enough to be affected
  p_backoff_drop_r7: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (accept && ovf_in && cur_scale >= SCALE_W'(128)) |=> (cur_scale < $past(cur_scale)));

  // R8: starting a divide closes the input until it completes
  p_busy_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
    div_start |=> !iter_ready);

  // R9: iteration counter advances exactly on acceptance
  p_iter_step_r9: assert property (@(posedge clk) disable iff (!rst_n || clr)
    accept |=> (iter_cnt == $past(iter_cnt) + 1'b1));

  // R6: an overflow iteration never starts a divide
  p_no_div_on_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (accept && ovf_in) |=> !div_busy);
endmodule

// File: tb/scale_tracker_tb.sv
module scale_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;
  localparam longint NUM = 64'd240 << 16;
  localparam logic [31:0] INIT = 32'h0100_0000;

  logic clk = 0, rst_n = 0, clr = 0, iter_valid = 0, ovf_in = 0;
  logic [15:0] amax = '0;
  logic iter_ready, scale_valid;
  logic [31:0] scale_out, cur_scale;
  logic [15:0] iter_cnt, ovf_cnt;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] m_hist [32];
  longint m_sum;
  logic [31:0] m_cur;
  int m_phase, m_iter, m_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  scale_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .iter_valid(iter_valid),
    .iter_ready(iter_ready), .amax(amax), .ovf_in(ovf_in),
    .scale_out(scale_out), .scale_valid(scale_valid), .cur_scale(cur_scale),
    .iter_cnt(iter_cnt), .ovf_cnt(ovf_cnt)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 32; k++) m_hist[k] = INIT;
    m_sum = longint'(INIT) * 32;
    m_cur = INIT; m_phase = 0; m_iter = 0; m_ovf = 0;
  endtask

  task automatic check_state(input string req);
    chk({req, " scale_out"}, scale_out, m_sum / 32);
    chk({req, " cur_scale"}, cur_scale, m_cur);
    chk({req, " iter_cnt"}, iter_cnt, m_iter % 65536);
    chk({req, " ovf_cnt"}, ovf_cnt, m_ovf);
    chk({req, " scale_valid"}, scale_valid, 1);
  endtask

  task automatic do_iter(input logic [15:0] a, input logic o);
    bit upd;
    int lowc;
    logic [31:0] q;
    @(negedge clk);
    while (!iter_ready) @(negedge clk);
    amax = a; ovf_in = o; iter_valid = 1;
    upd = !o && (m_phase == 0);
    if (o) begin
      m_ovf++;
      m_cur = m_cur - (m_cur >> 7) - (m_cur >> 9);
    end else if (upd) begin
      q = 32'(NUM / (longint'(a) + 1));
      m_cur = q;
      m_sum = m_sum + q - m_hist[31];
      for (int k = 31; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = q;
    end
    m_phase = (m_phase + 1) % P;
    m_iter++;
    @(negedge clk);
    chk("R3 ready after accept", iter_ready, !upd);
    if (upd) begin
      ovf_in = 1; amax = 16'h1234;
      lowc = 0;
      while (!iter_ready) begin lowc++; @(negedge clk); end
      chk("R8 busy cycles", lowc, 33);
    end
    iter_valid = 0; ovf_in = 0;
    check_state(upd ? "R2 R4 R5" : (o ? "R6 R7" : "R9"));
  endtask

  initial begin
    int guard = 0;
    while (!finished && guard < 150000) begin @(posedge clk); guard++; end
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", guard);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", iter_ready, 1);
    rst_n = 1;
    @(negedge clk);
    check_state("R1");
    chk("R1 ready", iter_ready, 1);
    do_iter(16'h0000, 0);
    chk("R4 amax zero", cur_scale, NUM);
    do_iter(16'hFFFF, 0);
    do_iter(16'h0100, 0);
    do_iter(16'h0200, 0);
    do_iter(16'hFFFF, 0);
    chk("R4 amax max", cur_scale, 240);
    for (int i = 0; i < 160; i++) begin
      logic [15:0] a;
      a = 16'((i * 977 + 13) ^ (i << 9));
      do_iter(a, (i % 7) == 3);
    end
    @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0;
    model_reset();
    check_state("R10 idle clear");
    @(negedge clk);
    amax = 16'h0040; iter_valid = 1;
    @(negedge clk);
    iter_valid = 0;
    repeat (5) @(negedge clk);
    chk("R8 still busy", iter_ready, 0);
    clr = 1;
    @(negedge clk);
    clr = 0;
    chk("R10 abort ready", iter_ready, 1);
    check_state("R10 abort");
    repeat (40) @(negedge clk);
    check_state("R10 no late push");
    for (int i = 0; i < 12; i++) do_iter(16'(i * 300 + 1), i == 5);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule